// File: doc/BRIEF.md
# Background ECC Strength Scheduler

This block steps memory regions from a heavy error-correcting code down to a light one as background testing builds confidence in them. The memory is divided into a fixed number of regions. After reset, all of them are protected by the heaviest code, which corrects four bits and detects five. A free-running interval timer paces the testing. Each time it expires, the block asks an external test engine to run one test round on a single region. Regions are visited in turn, so testing never covers the whole memory at once.

Each region keeps a count of the test rounds it has passed in a row. As that count crosses three thresholds, the region's code is weakened one step at a time. It goes first to three-correct/four-detect, then to double-correct/triple-detect, and finally to single-correct/double-detect. A failed round puts the region back on the heaviest code and clears its count. It also sets a sticky flag for that region. Every request to the test engine carries the doubled wait-interval guardband flag. The current level of every region is driven continuously on a flat vector for the codecs to use.

Top module: `ecc_profile_sched`

## Requirements
- R1: During and right after reset, every region is at level code 0 (heaviest), every failure flag is clear and `test_req` is low.
- R2: Region i's level sits at bits [2i+1:2i] of `lvl_all`. Code 0 means four-correct/five-detect, 1 means three-correct/four-detect, 2 means double-correct/triple-detect and 3 means single-correct/double-detect.
- R3: The timer expires once every INTERVAL cycles, with the first expiry counted from reset release. An expiry that finds no test outstanding raises `test_req` on the next clock, so the first request is high after INTERVAL clock edges.
- R4: Requests visit the regions in ascending order, wrapping from N-1 to 0, starting at region 0. `test_region` names the region under test and `test_guard` is always 1.
- R5: `test_req` stays high, with `test_region` unchanged, until a cycle with `test_done` high. A `test_done` that arrives while no request is outstanding changes nothing.
- R6: An expiry that occurs while a request is outstanding is held as a single pending expiry, and further expiries are dropped. The pending expiry issues the next request on the clock after the current one completes.
- R7: A clean completion (`test_fail` low) adds one to the region's clean count. The level is 1 once the count reaches TH1, 2 once it reaches TH2 and 3 once it reaches TH3.
- R8: The clean count saturates at TH3 and the level never goes past code 3.
- R9: A completion with `test_fail` high clears that region's count and returns it to level 0. It also sets that region's sticky bit in `fail_flags`, which only reset clears.
- R10: A completion changes the level and flag of the tested region only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_req | output | 1 | Test round requested, held until done |
| test_region | output | RW = clog2(N) | Region to test |
| test_guard | output | 1 | Doubled retention-wait guardband flag, constant 1 |
| test_done | input | 1 | Test engine finished the current round |
| test_fail | input | 1 | Qualifies `test_done`: the round found a failure |
| lvl_all | output | 2*N | Per-region ECC level codes |
| fail_flags | output | N | Sticky per-region failure flags |

## Verification
The bench builds the block with N=4, INTERVAL=8, TH1=2, TH2=10 and TH3=20. The short interval and small top threshold let every region reach saturation within a few thousand cycles. The modelled test engine sometimes takes 20 cycles to answer. That is long enough for two or more expiries to occur while one request is outstanding, so the single-pending-expiry rule is exercised. Failures are injected on two chosen rounds, and stray failing completions are sent while no request is outstanding. These cover the recovery path, the sticky flags and the ignore rule, all compared cycle by cycle against a behavioural model.

// File: rtl/ecc_sched_pkg.sv
package ecc_sched_pkg;
  typedef enum logic [1:0] {
    LVL_C4 = 2'd0,
    LVL_C3 = 2'd1,
    LVL_C2 = 2'd2,
    LVL_C1 = 2'd3
  } ecc_lvl_e;
endpackage

// File: rtl/sched_tick_timer.sv
module sched_tick_timer #(
  parameter int INTERVAL = 1024
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int TW = $clog2(INTERVAL + 1);
  localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

  logic [TW-1:0] tcnt_q, tcnt_n;

  always_comb begin
    tick   = (tcnt_q == LAST);
    tcnt_n = tick ? '0 : tcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tcnt_q <= '0;
    else        tcnt_q <= tcnt_n;
  end

  // R3: expiries are separated by at least one quiet cycle
  assert_tick_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && INTERVAL > 1) |=> !tick);
endmodule

// File: rtl/sched_dispatch.sv
module sched_dispatch #(
  parameter int N = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           tick,
  input  logic                           test_done,
  output logic                           test_req,
  output logic [((N > 1) ? $clog2(N) : 1)-1:0] test_region,
  output logic                           upd
);
  localparam int RW = (N > 1) ? $clog2(N) : 1;
  localparam logic [RW-1:0] LAST = RW'(N - 1);

  logic          busy_q, busy_n;
  logic          pend_q, pend_n;
  logic [RW-1:0] ptr_q, ptr_n;
  logic          start, fin;

  always_comb begin
    start  = !busy_q && (tick || pend_q);
    fin    = busy_q && test_done;
    busy_n = start ? 1'b1 : (fin ? 1'b0 : busy_q);
    pend_n = start ? (pend_q && tick) : (pend_q || (tick && busy_q));
    ptr_n  = fin ? ((ptr_q == LAST) ? '0 : ptr_q + 1'b1) : ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pend_q <= 1'b0;
      ptr_q  <= '0;
    end else begin
      busy_q <= busy_n;
      pend_q <= pend_n;
      ptr_q  <= ptr_n;
    end
  end

  assign test_req    = busy_q;
  assign test_region = ptr_q;
  assign upd         = fin;

  // R5: request held with a stable region until the engine answers
  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (test_req && !test_done) |=> (test_req && $stable(test_region)));
  // R5: a stray done leaves the region pointer alone
  assert_stray_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !test_req |=> $stable(test_region));
  // R4: completion advances to the next region with wrap
  assert_round_robin_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (test_req && test_done) |=> (test_region ==
      (($past(test_region) == LAST) ? '0 : $past(test_region) + 1'b1)));
  // R6: a new request only follows an expiry or a held expiry
  assert_start_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(test_req) |-> ($past(tick) || $past(pend_q)));
endmodule

// File: rtl/sched_region_track.sv
module sched_region_track
  import ecc_sched_pkg::*;
#(
  parameter int TH1 = 2,
  parameter int TH2 = 10,
  parameter int TH3 = 7000
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     upd,
  input  logic     fail,
  output ecc_lvl_e lvl,
  output logic     flag
);
  localparam int CW = $clog2(TH3 + 1);
  localparam logic [CW-1:0] T1 = CW'(TH1);
  localparam logic [CW-1:0] T2 = CW'(TH2);
  localparam logic [CW-1:0] T3 = CW'(TH3);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          flag_q, flag_n;

  always_comb begin
    cnt_n  = cnt_q;
    flag_n = flag_q;
    if (upd) begin
      if (fail) begin
        cnt_n  = '0;
        flag_n = 1'b1;
      end else if (cnt_q < T3) begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (upd) begin
      cnt_q  <= cnt_n;
      flag_q <= flag_n;
    end
  end

  always_comb begin
    if (cnt_q >= T3)      lvl = LVL_C1;
    else if (cnt_q >= T2) lvl = LVL_C2;
    else if (cnt_q >= T1) lvl = LVL_C3;
    else                  lvl = LVL_C4;
  end
  assign flag = flag_q;

  // R9: a failing round restores the heaviest code and raises the flag
  assert_fail_restore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && fail) |=> (lvl == LVL_C4 && flag));
  // R9: flag is sticky
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flag |=> flag);
  // R7: without a failure the code only gets lighter
  assert_monotone_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd && fail) |=> (lvl >= $past(lvl)));
  // R8: count saturates at the final threshold
  assert_saturate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= T3);
  // R10: no completion for this region, no change
  assert_untouched_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> ($stable(lvl) && $stable(flag)));
endmodule

// File: rtl/ecc_profile_sched.sv
module ecc_profile_sched
  import ecc_sched_pkg::*;
#(
  parameter int N        = 8,
  parameter int INTERVAL = 1024,
  parameter int TH1      = 2,
  parameter int TH2      = 10,
  parameter int TH3      = 7000
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  output logic                                 test_req,
  output logic [((N > 1) ? $clog2(N) : 1)-1:0] test_region,
  output logic                                 test_guard,
  input  logic                                 test_done,
  input  logic                                 test_fail,
  output logic [2*N-1:0]                       lvl_all,
  output logic [N-1:0]                         fail_flags
);
  localparam int RW = (N > 1) ? $clog2(N) : 1;

  logic tick;
  logic upd;

  sched_tick_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  sched_dispatch #(.N(N)) u_disp (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .test_done   (test_done),
    .test_req    (test_req),
    .test_region (test_region),
    .upd         (upd)
  );

  for (genvar i = 0; i < N; i++) begin : g_rgn
    ecc_lvl_e lvl_i;
    logic     hit_i;
    assign hit_i = upd && (test_region == RW'(i));

    sched_region_track #(.TH1(TH1), .TH2(TH2), .TH3(TH3)) u_trk (
      .clk   (clk),
      .rst_n (rst_n),
      .upd   (hit_i),
      .fail  (test_fail),
      .lvl   (lvl_i),
      .flag  (fail_flags[i])
    );
    assign lvl_all[2*i +: 2] = lvl_i;
  end

  assign test_guard = 1'b1;
endmodule

// File: tb/sim_ecc_profile_sched.sv
`timescale 1ns/1ps
module sim_ecc_profile_sched;
  localparam int N = 4, INTERVAL = 8, TH1 = 2, TH2 = 10, TH3 = 20;
  localparam int RW = 2;
  localparam int TARGET = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic test_done = 1'b0, test_fail = 1'b0;
  logic test_req, test_guard;
  logic [RW-1:0] test_region;
  logic [2*N-1:0] lvl_all;
  logic [N-1:0] fail_flags;

  int checks = 0, fails = 0, k = 0, cyc = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ecc_profile_sched #(.N(N), .INTERVAL(INTERVAL), .TH1(TH1), .TH2(TH2), .TH3(TH3)) u0 (
    .clk(clk), .rst_n(rst_n), .test_req(test_req), .test_region(test_region),
    .test_guard(test_guard), .test_done(test_done), .test_fail(test_fail),
    .lvl_all(lvl_all), .fail_flags(fail_flags));

  // behavioural reference
  int m_t = 0, m_ptr = 0;
  bit m_busy = 0, m_pend = 0;
  int m_cnt [N];
  bit m_flag [N];

  function automatic int lvl_of(int c);
    if (c >= TH3) return 3;
    if (c >= TH2) return 2;
    if (c >= TH1) return 1;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_t = 0; m_ptr = 0; m_busy = 0; m_pend = 0;
      for (int i = 0; i < N; i++) begin m_cnt[i] = 0; m_flag[i] = 0; end
    end else begin
      bit tk, st, fn;
      tk = (m_t == INTERVAL - 1);
      st = !m_busy && (tk || m_pend);
      fn = m_busy && test_done;
      if (st) m_pend = m_pend && tk;
      else    m_pend = m_pend || (tk && m_busy);
      if (fn) begin
        if (test_fail) begin m_cnt[m_ptr] = 0; m_flag[m_ptr] = 1; end
        else if (m_cnt[m_ptr] < TH3) m_cnt[m_ptr]++;
        m_ptr = (m_ptr + 1) % N;
      end
      if (st) m_busy = 1; else if (fn) m_busy = 0;
      m_t = tk ? 0 : m_t + 1;
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      cyc++;
      chk(test_req == m_busy, "R5/R6 test_req", test_req, m_busy);
      if (m_busy) chk(test_region == RW'(m_ptr), "R4 test_region", test_region, m_ptr);
      chk(test_guard == 1'b1, "R4 test_guard", test_guard, 1);
      for (int i = 0; i < N; i++) begin
        chk(lvl_all[2*i +: 2] == 2'(lvl_of(m_cnt[i])), "R2/R7/R10 level",
            lvl_all[2*i +: 2], lvl_of(m_cnt[i]));
        chk(fail_flags[i] == m_flag[i], "R9 flag", fail_flags[i], m_flag[i]);
      end
    end
  end

  // modelled test engine
  initial begin
    @(posedge rst_n);
    forever begin
      int lat;
      bit f;
      do @(negedge clk); while (!test_req);
      lat = (k % 5 == 3) ? 20 : 1 + (k % 3);
      f = (k == 30 || k == 61);
      repeat (lat - 1) @(negedge clk);
      test_done = 1'b1; test_fail = f;
      @(negedge clk);
      test_done = 1'b0; test_fail = 1'b0;
      k++;
      if (k % 7 == 0) begin
        // stray failing completion while nothing is outstanding (R5)
        test_done = 1'b1; test_fail = 1'b1;
        @(negedge clk);
        test_done = 1'b0; test_fail = 1'b0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", k, TARGET);
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(test_req == 1'b0, "R1 test_req in reset", test_req, 0);
    chk(lvl_all == '0, "R1 levels in reset", lvl_all, 0);
    chk(fail_flags == '0, "R1 flags in reset", fail_flags, 0);
    rst_n = 1'b1;
    // R3: first request after exactly INTERVAL edges
    repeat (INTERVAL - 1) @(negedge clk);
    chk(test_req == 1'b0, "R3 no request before interval", test_req, 0);
    @(negedge clk);
    chk(test_req == 1'b1, "R3 request at interval", test_req, 1);
    chk(test_region == '0, "R4 first region", test_region, 0);
    wait (k >= TARGET);
    repeat (4) @(negedge clk);
    chk(lvl_all[1:0] == 2'd3, "R8 region 0 saturated", lvl_all[1:0], 3);
    chk(lvl_all[7:6] == 2'd3, "R8 region 3 saturated", lvl_all[7:6], 3);
    chk(fail_flags == 4'b0110, "R9 sticky flags", fail_flags, 6);
    chk(fail_flags[0] == 1'b0, "R5 stray failing done ignored", fail_flags[0], 0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule